// File: doc/BRIEF.md
# Banked Per-Pin GPIO Configuration Register

This block configures a row of general-purpose pins, the count fixed by a parameter. Each pin has one byte-wide register address. Six 4-bit configuration banks per pin sit behind that address. A three-bit bank pointer, carried in every written byte, selects which bank a read returns. One flag bit in the written byte decides between two actions: move only the pointer, or move the pointer and also load the named bank.

The stored state drives each pad in logic. The direction mode, open-drain buffer type, output value, polarity and disable bits together produce the pad output value, its output enable and a tristate indication. Pad inputs are registered once and corrected for polarity. Bias, drive strength, supply and function codes are kept only as stored values, and they read back unchanged.

The host reaches the block through a plain synchronous register port. Read data is registered and appears one cycle after the read strobe.

Top module: `pincfg_bank_top`

## Requirements
- R1: Pin k answers at address BASE_ADDR + k (default 0x150 + k, k from 0). Writes to any other address change nothing, and reads of any other address return 0x00.
- R2: A write with bit 7 set loads bank wdata[6:4] with wdata[3:0] and sets that pin's bank pointer to wdata[6:4].
- R3: A write with bit 7 clear sets only the pin's bank pointer to wdata[6:4] and leaves every bank unchanged.
- R4: A read strobe returns {1'b0, pointer[2:0], bank[pointer][3:0]} on reg_rdata on the following cycle. Without a read strobe, reg_rdata holds its value.
- R5: Bank numbers 6 and 7 hold no storage. Writes to them leave all banks unchanged, and a pointer at 6 or 7 reads with a data nibble of 0.
- R6: After reset every bank holds 0 except bank 5, which holds 4'b1000 (non-inverted). Every pointer is 0, and pad_oe, pad_out and pad_tri are all 0.
- R7: Bank 1 bits 3:2 hold the direction mode: 0 input, 1 both, 2 output, 3 off. pad_oe can be 1 only in modes 1 and 2. Mode 3 sets pad_tri.
- R8: Bank 3 bit 0 set (disable) sets pad_tri and clears pad_oe in every mode.
- R9: Bank 1 bit 1 set (open-drain) asserts pad_oe only while the driven pad value is 0. Bank 1 bit 0 is the output value.
- R10: Bank 5 bit 3 clear inverts both the driven value on pad_out and the reported pin_level.
- R11: pin_level[k] reports pad_in[k], after the polarity of R10, one clock after it is sampled.
- R12: Bank 0 (supply code in bits 3:1, enable in bit 0), bank 2 (bias code in bits 3:1), bank 3 bits 3:2 (drive strength) and bank 4 (function code in bits 3:1) are stored as written and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write byte: bit 7 write flag, bits 6:4 bank, bits 3:0 data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_out | output | NUM_PINS | Pad drive value |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_tri | output | NUM_PINS | Pad forced to high impedance |
| pin_level | output | NUM_PINS | Sampled pad level after polarity |

## Verification
The bench gives most of its attention to the pointer-only write. A design that treats bit 7 as data, or ignores it, would overwrite a bank during a plain select. That shows up on the pads and on readback. Writes to banks 6 and 7 are also checked, because a design with a careless index would alias them onto a real bank and change the pad state. Open-drain with a high output value must float the pad, and disable must override output mode. The addresses just below the first pin and just past the last pin must stay silent, where an off-by-one decode would either drive a phantom pin or miss pin N-1.

// File: rtl/pincfg_pkg.sv
package pincfg_pkg;
    localparam int BANK_CNT = 6;
    localparam int BANK_W   = 4;
    localparam int PTR_W    = 3;

    localparam int B_SUPPLY = 0;
    localparam int B_DIR    = 1;
    localparam int B_BIAS   = 2;
    localparam int B_DRIVE  = 3;
    localparam int B_FUNC   = 4;
    localparam int B_POLAR  = 5;

    typedef enum logic [1:0] {
        DIR_IN   = 2'd0,
        DIR_BOTH = 2'd1,
        DIR_OUT  = 2'd2,
        DIR_OFF  = 2'd3
    } dir_mode_e;

    typedef logic [BANK_CNT-1:0][BANK_W-1:0] bank_arr_t;

    typedef struct packed {
        bank_arr_t        bank;
        logic [PTR_W-1:0] ptr;
        logic             in_q;
    } pin_state_t;

    // Bank 5 bit 3 set: pin starts non-inverted
    localparam bank_arr_t BANK_RST = bank_arr_t'(24'h80_0000);
endpackage

// File: rtl/pincfg_addr_dec.sv
module pincfg_addr_dec #(
    parameter int NUM_PINS  = 44,
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 'h150
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_PINS-1:0] sel,
    output logic                hit
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = addr - ADDR_W'(BASE_ADDR);
    end

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_sel
        assign sel[k] = (offset == ADDR_W'(k));
    end

    assign hit = |sel;
endmodule

// File: rtl/pincfg_pin.sv
module pincfg_pin
    import pincfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       pad_in,
    output logic [7:0] rd_word,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       pad_tri,
    output logic       pin_level
);
    pin_state_t st_d, st_q;

    logic             wr_flag;
    logic [PTR_W-1:0] wr_bank;
    dir_mode_e        mode;
    logic             open_drain, out_val, disabled, invert, drive_val;
    logic [BANK_W-1:0] sel_data;

    assign wr_flag = wdata[7];
    assign wr_bank = wdata[6:4];

    always_comb begin
        st_d      = st_q;
        st_d.in_q = pad_in;
        if (wr_en) begin
            st_d.ptr = wr_bank;
            if (wr_flag) begin
                for (int b = 0; b < BANK_CNT; b++) begin
                    if (wr_bank == PTR_W'(b)) st_d.bank[b] = wdata[BANK_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bank <= BANK_RST;
            st_q.ptr  <= '0;
            st_q.in_q <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mode       = dir_mode_e'(st_q.bank[B_DIR][3:2]);
        open_drain = st_q.bank[B_DIR][1];
        out_val    = st_q.bank[B_DIR][0];
        disabled   = st_q.bank[B_DRIVE][0];
        invert     = ~st_q.bank[B_POLAR][3];
        drive_val  = out_val ^ invert;
        pad_tri    = disabled || (mode == DIR_OFF);
        pad_oe     = !pad_tri && ((mode == DIR_OUT) || (mode == DIR_BOTH))
                     && !(open_drain && drive_val);
        pad_out    = drive_val;
        pin_level  = st_q.in_q ^ invert;
    end

    always_comb begin
        sel_data = '0;
        for (int b = 0; b < BANK_CNT; b++) begin
            if (st_q.ptr == PTR_W'(b)) sel_data = st_q.bank[b];
        end
        rd_word = {1'b0, st_q.ptr, sel_data};
    end

    // R3
    ptr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[7]) |=> $stable(st_q.bank));

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_word[6:4] == $past(wdata[6:4])));

    // R5
    void_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[7] && (wdata[6:4] >= 3'd6)) |=> $stable(st_q.bank));

    // R8
    tri_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_tri |-> !pad_oe);

    // R9
    od_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bank[B_DIR][1] && pad_out) |-> !pad_oe);
endmodule

// File: rtl/pincfg_bank_top.sv
module pincfg_bank_top
    import pincfg_pkg::*;
#(
    parameter int NUM_PINS  = 44,
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 'h150
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic                reg_we,
    input  logic                reg_re,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_tri,
    output logic [NUM_PINS-1:0] pin_level
);
    logic [NUM_PINS-1:0]      sel;
    logic                     hit;
    logic [NUM_PINS-1:0][7:0] words;
    logic [7:0]               rd_mux;
    logic [7:0]               rdata_d, rdata_q;

    pincfg_addr_dec #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .addr(reg_addr),
        .sel (sel),
        .hit (hit)
    );

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        pincfg_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && sel[k]),
            .wdata    (reg_wdata),
            .pad_in   (pad_in[k]),
            .rd_word  (words[k]),
            .pad_out  (pad_out[k]),
            .pad_oe   (pad_oe[k]),
            .pad_tri  (pad_tri[k]),
            .pin_level(pin_level[k])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_PINS; k++) begin
            if (sel[k]) rd_mux = rd_mux | words[k];
        end
        rdata_d = rdata_q;
        if (reg_re) rdata_d = hit ? rd_mux : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= 8'h00;
        else        rdata_q <= rdata_d;
    end

    assign reg_rdata = rdata_q;

    // R1
    oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && !hit) |=> (reg_rdata == 8'h00));

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata));
endmodule

// File: tb/pincfg_bank_top_bench.sv
module pincfg_bank_top_bench;
    localparam int N = 44;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic          reg_re = 1'b0;
    logic [7:0]    reg_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_tri, pin_level;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pincfg_bank_top u_pincfg_bank_top (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_tri(pad_tri), .pin_level(pin_level)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R6 oe", 64'(pad_oe), 64'd0);
        chk("R6 out", 64'(pad_out), 64'd0);
        chk("R6 tri", 64'(pad_tri), 64'd0);
        rd(12'h150, d); chk("R6 bank0", 64'(d), 64'h00);
        wr(12'h150, 8'h50);
        rd(12'h150, d); chk("R6 bank5", 64'(d), 64'h58);
    endtask

    task automatic t_write_select;
        logic [7:0] d;
        wr(12'h150, 8'h99);
        chk("R2 oe", 64'(pad_oe[0]), 64'd1);
        chk("R2 out", 64'(pad_out[0]), 64'd1);
        rd(12'h150, d); chk("R2 read", 64'(d), 64'h19);
        wr(12'h150, 8'h30);
        chk("R3 oe kept", 64'(pad_oe[0]), 64'd1);
        rd(12'h150, d); chk("R3 read", 64'(d), 64'h30);
        wr(12'h150, 8'h10);
        rd(12'h150, d); chk("R3 bank1 kept", 64'(d), 64'h19);
        wr(12'h150, 8'h80);
        repeat (3) @(negedge clk);
        chk("R4 hold", 64'(reg_rdata), 64'h19);
    endtask

    task automatic t_modes;
        wr(12'h150, 8'h95);
        chk("R7 both oe", 64'(pad_oe[0]), 64'd1);
        wr(12'h150, 8'h9D);
        chk("R7 off oe", 64'(pad_oe[0]), 64'd0);
        chk("R7 off tri", 64'(pad_tri[0]), 64'd1);
        wr(12'h150, 8'h91);
        chk("R7 in oe", 64'(pad_oe[0]), 64'd0);
        chk("R7 in tri", 64'(pad_tri[0]), 64'd0);
        wr(12'h150, 8'h99);
        wr(12'h150, 8'hB1);
        chk("R8 tri", 64'(pad_tri[0]), 64'd1);
        chk("R8 oe", 64'(pad_oe[0]), 64'd0);
        wr(12'h150, 8'hB0);
        chk("R8 release", 64'(pad_oe[0]), 64'd1);
    endtask

    task automatic t_open_drain;
        wr(12'h150, 8'h9B);
        chk("R9 high floats", 64'(pad_oe[0]), 64'd0);
        chk("R9 out", 64'(pad_out[0]), 64'd1);
        wr(12'h150, 8'h9A);
        chk("R9 low drives", 64'(pad_oe[0]), 64'd1);
        chk("R9 out low", 64'(pad_out[0]), 64'd0);
    endtask

    task automatic t_polarity;
        wr(12'h150, 8'h99);
        @(negedge clk); pad_in[0] = 1'b1;
        @(negedge clk);
        chk("R11 level", 64'(pin_level[0]), 64'd1);
        wr(12'h150, 8'hD0);
        chk("R10 out inv", 64'(pad_out[0]), 64'd0);
        chk("R10 level inv", 64'(pin_level[0]), 64'd0);
        @(negedge clk); pad_in[0] = 1'b0;
        @(negedge clk);
        chk("R11 level inv", 64'(pin_level[0]), 64'd1);
        wr(12'h150, 8'hD8);
        chk("R10 restore", 64'(pad_out[0]), 64'd1);
    endtask

    task automatic t_void_banks;
        logic [7:0] d;
        wr(12'h150, 8'hE5);
        rd(12'h150, d); chk("R5 read bank6", 64'(d), 64'h60);
        wr(12'h150, 8'hF3);
        rd(12'h150, d); chk("R5 read bank7", 64'(d), 64'h70);
        chk("R5 pads kept", 64'(pad_oe[0]), 64'd1);
        wr(12'h150, 8'h10);
        rd(12'h150, d); chk("R5 bank1 kept", 64'(d), 64'h19);
        wr(12'h150, 8'h50);
        rd(12'h150, d); chk("R5 bank5 kept", 64'(d), 64'h58);
    endtask

    task automatic t_codes;
        logic [7:0] d;
        wr(12'h150, 8'h8E); rd(12'h150, d); chk("R12 supply", 64'(d), 64'h0E);
        wr(12'h150, 8'hAA); rd(12'h150, d); chk("R12 bias", 64'(d), 64'h2A);
        wr(12'h150, 8'hBC); rd(12'h150, d); chk("R12 drive", 64'(d), 64'h3C);
        wr(12'h150, 8'hCE); rd(12'h150, d); chk("R12 func", 64'(d), 64'h4E);
        chk("R12 no disable", 64'(pad_oe[0]), 64'd1);
    endtask

    task automatic t_addr;
        logic [7:0] d;
        wr(12'h17B, 8'h99);
        chk("R1 last pin", 64'(pad_oe), 64'h800_0000_0001);
        wr(12'h17C, 8'h99);
        wr(12'h14F, 8'h99);
        chk("R1 oor writes", 64'(pad_oe), 64'h800_0000_0001);
        rd(12'h17C, d); chk("R1 read above", 64'(d), 64'h00);
        rd(12'h14F, d); chk("R1 read below", 64'(d), 64'h00);
        rd(12'h17B, d); chk("R1 read last", 64'(d), 64'h19);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_select();
        t_modes();
        t_open_drain();
        t_polarity();
        t_void_banks();
        t_codes();
        t_addr();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule